// File: doc/BRIEF.md
# Remapped GPIO Port Controller

This block lends sixteen lines of an eighteen-pin parallel data port to software as general-purpose I/O. The lines are lent only while two mode inputs are both high: one says the device is doing quadrature upconversion, the other says the two-wire serial interface is selected. Two port lines, 5 and 4, stay with the serial interface in every mode. The other sixteen lines pack into a 16-bit register image with no gap. Software programs a direction register and a data register through a simple register read/write interface. Output lines drive the stored data bit. Input lines are synchronized and then returned on a data read.

When either mode input is low, every port line carries the normal data path's output value and output enable. The two registers keep their contents across such a mode change. A data write takes effect on the pins at the same clock edge that stores it. No separate update strobe exists. Pin values, output enables and read data all leave the block from flip-flops.

Top module: `gpio_remap_port`

## Requirements
- R1: While reset is high, the next clock edge clears the direction and data registers, the pin output value, the pin output enable and the read data to zero.
- R2: GPIO ownership holds only when both mode_qduc and mode_twowire are 1. At any edge where it does not hold, pin_out and pin_oe take dp_out and dp_oe for all 18 lines, whatever the direction register holds. Both registers keep their contents.
- R3: Port lines 5 and 4 always take dp_out and dp_oe at the next edge, in every mode.
- R4: Register bit r maps to port line r for r in 0..3, and to port line r+2 for r in 4..15.
- R5: In GPIO mode, a direction bit of 1 enables the mapped line's output and a bit of 0 makes it an input, with pin_oe low.
- R6: In GPIO mode, an output line drives its data register bit, and an input line drives 0 on pin_out.
- R7: A register write applied at a clock edge is reflected on pin_oe and pin_out right after that same edge, with no further strobe.
- R8: A read with reg_addr=1 (data) returns, one edge later, the stored data bit for output bits. For input bits it returns the mapped pin level sampled two edges before the read edge, through a two-stage synchronizer.
- R9: A read with reg_addr=0 (config) returns the direction register. A read and a write in the same cycle return the value from before the write. reg_rdata holds its value in cycles where reg_rd is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_qduc | input | 1 | Quadrature upconversion mode selected |
| mode_twowire | input | 1 | Two-wire serial interface mode selected |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 = direction register, 1 = data register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| dp_out | input | 18 | Normal data path output values |
| dp_oe | input | 18 | Normal data path output enables |
| pin_in | input | 18 | Levels present on the port lines |
| pin_out | output | 18 | Registered output value per port line |
| pin_oe | output | 18 | Registered output enable per port line |

## Verification
On every cycle the assertions check these properties: the release of all lines to the data path outside GPIO mode, the pass-through of lines 5 and 4, direction bits matching the mapped output enables, held read data between reads, and input bits of a data read matching the synchronizer output. The exact line mapping, the same-edge effect of writes, the two-edge input latency and the old-value result of a simultaneous read and write are shown only by the bench. Its behavioural model compares every output on every clock over directed walks and long random runs with mode toggling.

// File: rtl/gpio_remap_pkg.sv
package gpio_remap_pkg;

  localparam int GP_REG_W  = 16;
  localparam int GP_RSV_LO = 4;
  localparam int GP_RSV_W  = 2;
  localparam int GP_PORT_W = GP_REG_W + GP_RSV_W;

  typedef enum logic {
    SEL_DIR  = 1'b0,
    SEL_DATA = 1'b1
  } gp_sel_e;

  // Port line that carries register bit r.
  function automatic int gp_line_of(input int r);
    return (r < GP_RSV_LO) ? r : r + GP_RSV_W;
  endfunction

  // Spread a register image onto port-line positions (reserved lines zero).
  function automatic logic [GP_PORT_W-1:0] gp_spread(input logic [GP_REG_W-1:0] v);
    logic [GP_PORT_W-1:0] o;
    o = '0;
    for (int r = 0; r < GP_REG_W; r++) begin
      o[gp_line_of(r)] = v[r];
    end
    return o;
  endfunction

endpackage

// File: rtl/gpio_remap_regs.sv
module gpio_remap_regs
  import gpio_remap_pkg::*;
#(
  parameter int REG_W = GP_REG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] dir_q,
  output logic [REG_W-1:0] dat_q,
  output logic [REG_W-1:0] dir_nxt,
  output logic [REG_W-1:0] dat_nxt
);

  always_comb begin
    dir_nxt = dir_q;
    dat_nxt = dat_q;
    if (wr_en) begin
      if (gp_sel_e'(wr_sel) == SEL_DIR) dir_nxt = wr_data;
      else                              dat_nxt = wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      dat_q <= '0;
    end else begin
      dir_q <= dir_nxt;
      dat_q <= dat_nxt;
    end
  end

endmodule

// File: rtl/gpio_remap_sync.sv
module gpio_remap_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_remap_pinmux.sv
module gpio_remap_pinmux #(
  parameter int REG_W  = 16,
  parameter int RSV_LO = 4,
  parameter int RSV_W  = 2,
  localparam int PORT_W = REG_W + RSV_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gpio_on,
  input  logic [REG_W-1:0]  dir_nxt,
  input  logic [REG_W-1:0]  dat_nxt,
  input  logic [PORT_W-1:0] dp_out,
  input  logic [PORT_W-1:0] dp_oe,
  input  logic [PORT_W-1:0] pin_in,
  output logic [REG_W-1:0]  gp_in,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe
);

  logic [PORT_W-1:0] out_d;
  logic [PORT_W-1:0] oe_d;

  for (genvar p = 0; p < PORT_W; p++) begin : g_line
    if (p >= RSV_LO && p < RSV_LO + RSV_W) begin : g_reserved
      assign oe_d[p]  = dp_oe[p];
      assign out_d[p] = dp_out[p];
    end else begin : g_gpio
      localparam int R = (p < RSV_LO) ? p : p - RSV_W;
      assign oe_d[p]  = gpio_on ? dir_nxt[R] : dp_oe[p];
      assign out_d[p] = gpio_on ? (dir_nxt[R] & dat_nxt[R]) : dp_out[p];
      assign gp_in[R] = pin_in[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_oe  <= '0;
      pin_out <= '0;
    end else begin
      pin_oe  <= oe_d;
      pin_out <= out_d;
    end
  end

endmodule

// File: rtl/gpio_remap_readback.sv
module gpio_remap_readback
  import gpio_remap_pkg::*;
#(
  parameter int REG_W = GP_REG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic             rd_sel,
  input  logic [REG_W-1:0] dir_q,
  input  logic [REG_W-1:0] dat_q,
  input  logic [REG_W-1:0] gp_sync,
  output logic [REG_W-1:0] rdata
);

  logic [REG_W-1:0] data_view;

  assign data_view = (dat_q & dir_q) | (gp_sync & ~dir_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= (gp_sel_e'(rd_sel) == SEL_DATA) ? data_view : dir_q;
    end
  end

endmodule

// File: rtl/gpio_remap_port.sv
module gpio_remap_port
  import gpio_remap_pkg::*;
#(
  parameter int REG_W       = GP_REG_W,
  parameter int RSV_LO      = GP_RSV_LO,
  parameter int RSV_W       = GP_RSV_W,
  parameter int SYNC_STAGES = 2,
  localparam int PORT_W     = REG_W + RSV_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_qduc,
  input  logic              mode_twowire,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [PORT_W-1:0] dp_out,
  input  logic [PORT_W-1:0] dp_oe,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe
);

  logic             gpio_on;
  logic [REG_W-1:0] dir_q;
  logic [REG_W-1:0] dat_q;
  logic [REG_W-1:0] dir_nxt;
  logic [REG_W-1:0] dat_nxt;
  logic [REG_W-1:0] gp_in;
  logic [REG_W-1:0] gp_sync;

  assign gpio_on = mode_qduc & mode_twowire;

  gpio_remap_regs #(.REG_W(REG_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr),
    .wr_sel  (reg_addr),
    .wr_data (reg_wdata),
    .dir_q   (dir_q),
    .dat_q   (dat_q),
    .dir_nxt (dir_nxt),
    .dat_nxt (dat_nxt)
  );

  gpio_remap_pinmux #(.REG_W(REG_W), .RSV_LO(RSV_LO), .RSV_W(RSV_W)) u_mux (
    .clk     (clk),
    .rst     (rst),
    .gpio_on (gpio_on),
    .dir_nxt (dir_nxt),
    .dat_nxt (dat_nxt),
    .dp_out  (dp_out),
    .dp_oe   (dp_oe),
    .pin_in  (pin_in),
    .gp_in   (gp_in),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
  );

  gpio_remap_sync #(.WIDTH(REG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (gp_in),
    .q   (gp_sync)
  );

  gpio_remap_readback #(.REG_W(REG_W)) u_rdbk (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (reg_rd),
    .rd_sel  (reg_addr),
    .dir_q   (dir_q),
    .dat_q   (dat_q),
    .gp_sync (gp_sync),
    .rdata   (reg_rdata)
  );

endmodule

// File: rtl/gpio_remap_chk.sv
module gpio_remap_chk
  import gpio_remap_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 gpio_on,
  input logic                 reg_rd,
  input logic                 reg_addr,
  input logic [GP_REG_W-1:0]  reg_rdata,
  input logic [GP_REG_W-1:0]  dir_q,
  input logic [GP_REG_W-1:0]  gp_sync,
  input logic [GP_PORT_W-1:0] dp_out,
  input logic [GP_PORT_W-1:0] dp_oe,
  input logic [GP_PORT_W-1:0] pin_out,
  input logic [GP_PORT_W-1:0] pin_oe
);

  localparam logic [GP_PORT_W-1:0] GPIO_MASK = gp_spread('1);
  localparam logic [GP_PORT_W-1:0] RSV_MASK  = ~GPIO_MASK;

  // R1: reset clears outputs
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 && pin_out == '0 && reg_rdata == '0));

  // R2: outside GPIO mode every line follows the data path
  a_r2_release: assert property (@(posedge clk) disable iff (rst)
    !gpio_on |=> (pin_oe == $past(dp_oe) && pin_out == $past(dp_out)));

  // R3: reserved lines always follow the data path
  a_r3_reserved: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pin_oe & RSV_MASK) == ($past(dp_oe) & RSV_MASK) &&
              (pin_out & RSV_MASK) == ($past(dp_out) & RSV_MASK)));

  // R5: in GPIO mode enables follow the direction register
  a_r5_dir_enable: assert property (@(posedge clk) disable iff (rst)
    gpio_on |=> ((pin_oe & GPIO_MASK) == gp_spread(dir_q)));

  // R8: input bits of a data read come from the synchronizer
  a_r8_input_sync: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == SEL_DATA) |=>
      (((reg_rdata ^ $past(gp_sync)) & ~$past(dir_q)) == '0));

  // R9: read data holds without a read
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));

endmodule

bind gpio_remap_port gpio_remap_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .gpio_on   (gpio_on),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .dir_q     (dir_q),
  .gp_sync   (gp_sync),
  .dp_out    (dp_out),
  .dp_oe     (dp_oe),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe)
);

// File: tb/test_gpio_remap_port.sv
`timescale 1ns/1ps
module test_gpio_remap_port;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_qduc = 1'b0;
  logic        mode_twowire = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic        reg_addr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [17:0] dp_out = '0;
  logic [17:0] dp_oe = '0;
  logic [17:0] pin_in = '0;
  logic [17:0] pin_out;
  logic [17:0] pin_oe;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_remap_port i_gpio_remap_port (
    .clk(clk), .rst(rst), .mode_qduc(mode_qduc), .mode_twowire(mode_twowire),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dp_out(dp_out), .dp_oe(dp_oe), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // Mapping as stated in R4
  function automatic logic [17:0] to_lines(input logic [15:0] v);
    return {v[15:4], 2'b00, v[3:0]};
  endfunction
  function automatic logic [15:0] from_lines(input logic [17:0] v);
    return {v[17:6], v[3:0]};
  endfunction

  localparam logic [17:0] RSV = 18'h00030;

  // Behavioural reference model
  logic [15:0] m_dir, m_dat, e_rd;
  logic [17:0] e_oe, e_out;
  logic        m_gpio;
  string       rd_tag;
  logic [15:0] hist[$];

  always @(posedge clk) begin
    logic [15:0] seen, old_dir, old_dat;
    if (rst) begin
      m_dir = '0; m_dat = '0; e_rd = '0; e_oe = '0; e_out = '0;
      m_gpio = 1'b0; rd_tag = "R1 reset readback";
      hist = '{16'h0, 16'h0};
    end else begin
      old_dir = m_dir; old_dat = m_dat;
      seen = hist.pop_front();
      hist.push_back(from_lines(pin_in));
      if (reg_rd) begin
        if (reg_addr) begin
          e_rd = (old_dat & old_dir) | (seen & ~old_dir);
          rd_tag = "R8 data readback";
        end else begin
          e_rd = old_dir;
          rd_tag = "R9 config readback";
        end
      end else begin
        rd_tag = "R9 rdata hold";
      end
      if (reg_wr) begin
        if (reg_addr) m_dat = reg_wdata; else m_dir = reg_wdata;
      end
      m_gpio = mode_qduc && mode_twowire;
      if (m_gpio) begin
        e_oe  = (dp_oe & RSV) | to_lines(m_dir);
        e_out = (dp_out & RSV) | to_lines(m_dir & m_dat);
      end else begin
        e_oe  = dp_oe;
        e_out = dp_out;
      end
    end
  end

  task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!done && $time > 15) begin
      if (!m_gpio) begin
        chk("R2 released pin_oe", pin_oe, e_oe);
        chk("R2 released pin_out", pin_out, e_out);
      end else begin
        chk("R3 reserved lines oe", pin_oe & RSV, e_oe & RSV);
        chk("R3 reserved lines out", pin_out & RSV, e_out & RSV);
        chk("R5 direction enables", pin_oe & ~RSV, e_oe & ~RSV);
        chk("R6 output values", pin_out & ~RSV, e_out & ~RSV);
      end
      chk(rd_tag, {2'b00, reg_rdata}, {2'b00, e_rd});
    end
  end

  task automatic cyc(input logic wr, input logic addr, input logic [15:0] wd, input logic rd);
    reg_wr = wr; reg_addr = addr; reg_wdata = wd; reg_rd = rd;
    dp_out = 18'($urandom); dp_oe = 18'($urandom);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset pin_oe", pin_oe, 18'h0);
    chk("R1 reset pin_out", pin_out, 18'h0);
    chk("R1 reset rdata", {2'b00, reg_rdata}, 18'h0);
    rst = 1'b0;

    // R2: not in GPIO mode, registers programmed but lines released
    mode_qduc = 1'b1; mode_twowire = 1'b0;
    cyc(1, 0, 16'hFFFF, 0);
    cyc(1, 1, 16'hA5A5, 0);
    for (int i = 0; i < 100; i++) cyc(0, 0, 16'h0, 0);
    mode_qduc = 1'b0; mode_twowire = 1'b1;
    for (int i = 0; i < 50; i++) cyc(0, 0, 16'h0, 0);
    cyc(0, 0, 16'h0, 1);
    cyc(0, 0, 16'h0, 0);
    chk("R2 registers kept", {2'b00, reg_rdata}, 18'h0FFFF);

    // R4: walking one through the direction register
    mode_qduc = 1'b1; mode_twowire = 1'b1;
    cyc(1, 1, 16'hFFFF, 0);
    for (int i = 0; i < 16; i++) begin
      cyc(1, 0, 16'(1) << i, 0);
      chk("R4 line map oe", pin_oe & ~RSV, (i < 4) ? (18'(1) << i) : (18'(1) << (i + 2)));
      chk("R4 line map out", pin_out & ~RSV, (i < 4) ? (18'(1) << i) : (18'(1) << (i + 2)));
    end

    // R7: data write visible right after its edge
    cyc(1, 0, 16'hFFFF, 0);
    cyc(1, 1, 16'h1234, 0);
    chk("R7 immediate data", pin_out & ~RSV, 18'h048D4 & ~RSV);
    cyc(1, 1, 16'hF00F, 0);
    chk("R7 immediate data", pin_out & ~RSV, {12'hF00, 2'b00, 4'hF});

    // R8: input readback through synchronizer
    cyc(1, 0, 16'h00FF, 0);
    for (int i = 0; i < 20; i++) begin
      pin_in = 18'($urandom);
      cyc(0, 1, 16'h0, (i % 3) != 0);
      cyc(0, 1, 16'h0, 1);
    end

    // R9: read and write in the same cycle return the old value
    cyc(1, 0, 16'h3C3C, 0);
    cyc(1, 0, 16'hBEEF, 1);
    chk("R9 read before write", {2'b00, reg_rdata}, 18'h03C3C);

    // Random traffic with mode toggling
    for (int i = 0; i < 3000; i++) begin
      if ((i % 37) == 0) begin
        mode_qduc = 1'($urandom); mode_twowire = 1'($urandom);
      end
      if ((i % 3) == 0) pin_in = 18'($urandom);
      cyc(1'($urandom), 1'($urandom), 16'($urandom), 1'($urandom));
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule